// File: doc/BRIEF.md
# Streaming Pairwise Cross-Correlator

This block correlates a time-multiplexed stream of antenna samples. Each sample word carries one complex value per polarisation, 4-bit signed with 3 fractional bits for each part. The stream visits every antenna in turn. Each antenna holds the bus for a fixed slot of `SLOT_LEN` clocks, and after the last antenna the sequence starts again at antenna 0. Delay lines of one slot each feed the block. With them it multiplies the current antenna against itself and against the antennas that came one, two and more slots earlier. This yields every pair of antennas, autocorrelations included. For each pair it forms four polarisation products, and the older antenna of each pair is conjugated.

Each product is summed over a whole slot in a saturating accumulator. When the slot closes, the sums for all lags leave the block one per clock, in order of increasing lag. Each result carries the indices of both antennas. For an even antenna count, the largest lag visits every pair twice in a frame. The second visit of each pair is marked so that downstream logic can discard it. Input is taken on every clock, and there is no flow control. A sync pulse marks the first sample of antenna 0.

Top module: `pair_correlator`

## Requirements
- R1: `sample_i` holds two complex values: bits 15:12 are the x-polarisation real part, 11:8 x imaginary, 7:4 y real and 3:0 y imaginary. Each is a two's-complement 4-bit value.
- R2: The sample taken on the clock where `sync_i` is high is cycle 0 of the slot for antenna 0. Slots last `SLOT_LEN` clocks, and antennas follow as 0, 1, ..., N_ANT-1, then repeat. A result from slot s reports `out_ant_a_o` = s.
- R3: For lag k in 0..N_ANT/2, slot s pairs antenna s with antenna b = (s-k) mod N_ANT, whose sample arrived k*SLOT_LEN clocks earlier. `out_ant_b_o` reports b. Each term is a*conj(b), and the four terms are xx = ax*conj(bx), yy = ay*conj(by), xy = ax*conj(by) and yx = ay*conj(bx).
- R4: Each real and each imaginary sum starts from zero on the first cycle of a slot and adds one product per clock across the slot. After every addition it is clamped to the signed range of `ACC_W` bits.
- R5: The result for lag k has `out_valid_o` high on the single cycle that follows the (k+1)-th rising edge after the edge that takes the slot's last sample. Lags 0 to N_ANT/2 therefore appear on consecutive cycles, and `out_valid_o` is low on all other cycles.
- R6: `out_data_o` packs eight `ACC_W`-bit fields, from the most significant down: xx re, xx im, yy re, yy im, xy re, xy im, yx re, yx im. Each field has 6 fractional bits.
- R7: `out_dup_o` is high only with a valid result, and only when N_ANT is even, the lag is N_ANT/2 and `out_ant_a_o` >= N_ANT/2.
- R8: No result is valid before the first sync, nor from any slot that starts less than one full frame (N_ANT slots) after the last realignment.
- R9: A sync on the clock where the counters are already at antenna 0, cycle 0 has no effect. Any other sync realigns the counters, restarts the priming of R8, drops a result burst in progress (output invalid from the next cycle) and drops results not yet sent.
- R10: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Marks cycle 0 of antenna 0's slot |
| sample_i | input | 16 | Dual-polarisation complex sample |
| out_valid_o | output | 1 | Result present |
| out_ant_a_o | output | $clog2(N_ANT) | Newer (unconjugated) antenna |
| out_ant_b_o | output | $clog2(N_ANT) | Older (conjugated) antenna |
| out_dup_o | output | 1 | Redundant pair, to be discarded |
| out_data_o | output | 8*ACC_W | Four accumulated complex terms |

## Verification
Two events can fall on the same clock. One is a misaligned sync. The other is the serial output of a finished slot, or the snapshot that starts it. To provoke the overlap, the bench issues a sync one cycle after a slot boundary, while the lag-0 result of the previous slot is on the outputs. It expects the rest of that burst to be suppressed, and no further results for one full frame. The bench also runs the accumulators into both clamps with extreme antenna patterns. Its model clamps after every addition, so any wrap or late clamp shows up as a data mismatch.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;
  localparam int SAMP_W  = 16;
  localparam int PROD_W  = 9;   // sum of two 4x4 signed products
  localparam int N_TERMS = 4;   // xx, yy, xy, yx

  typedef struct packed {
    logic signed [3:0] re;
    logic signed [3:0] im;
  } cplx4_t;

  typedef struct packed {
    cplx4_t x;
    cplx4_t y;
  } dual_samp_t;
endpackage

// File: rtl/xcorr_slot_timer.sv
module xcorr_slot_timer #(
  parameter int N_ANT    = 4,
  parameter int SLOT_LEN = 128,
  localparam int CYC_W   = $clog2(SLOT_LEN),
  localparam int ANT_W   = $clog2(N_ANT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  output logic [CYC_W-1:0] cyc_o,
  output logic [ANT_W-1:0] slot_o,
  output logic             active_o,
  output logic             first_o,
  output logic             last_o,
  output logic             realign_o,
  output logic             primed_o
);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(SLOT_LEN - 1);
  localparam logic [ANT_W-1:0] ANT_LAST = ANT_W'(N_ANT - 1);

  logic [CYC_W-1:0] cyc_q;
  logic [ANT_W-1:0] slot_q;
  logic             run_q, prim_q;
  logic             aligned;

  always_comb begin
    aligned   = run_q && (cyc_q == '0) && (slot_q == '0);
    realign_o = sync_i && !aligned;
    cyc_o     = realign_o ? '0 : cyc_q;
    slot_o    = realign_o ? '0 : slot_q;
    active_o  = run_q || sync_i;
    first_o   = cyc_o == '0;
    last_o    = active_o && (cyc_o == CYC_LAST);
    primed_o  = prim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      slot_q <= '0;
      run_q  <= 1'b0;
      prim_q <= 1'b0;
    end else begin
      run_q <= run_q | sync_i;
      if (active_o) begin
        if (last_o) begin
          cyc_q  <= '0;
          slot_q <= (slot_o == ANT_LAST) ? '0 : slot_o + 1'b1;
        end else begin
          cyc_q  <= cyc_o + 1'b1;
          slot_q <= slot_o;
        end
      end
      if (realign_o)                          prim_q <= 1'b0;
      else if (last_o && slot_o == ANT_LAST)  prim_q <= 1'b1;
    end
  end
endmodule

// File: rtl/xcorr_delay_line.sv
module xcorr_delay_line #(
  parameter int DEPTH = 128,
  parameter int W     = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [W-1:0]     din_i,
  output logic [W-1:0]     dout_o
);
  logic [W-1:0] mem [DEPTH];

  // read-before-write at the same pointer gives exactly DEPTH cycles of delay
  assign dout_o = mem[ptr_i];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[ptr_i] <= din_i;
  end
endmodule

// File: rtl/xcorr_cmac.sv
module xcorr_cmac
  import xcorr_pkg::*;
#(
  parameter int ACC_W = 16,
  localparam int OUT_W = 2 * N_TERMS * ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             first_i,
  input  dual_samp_t       a_i,
  input  dual_samp_t       b_i,
  output logic [OUT_W-1:0] sum_o
);
  localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] acc,
                                               input logic [PROD_W-1:0] p);
    logic [ACC_W:0] s;
    s = {acc[ACC_W-1], acc} + {{(ACC_W+1-PROD_W){p[PROD_W-1]}}, p};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return s[ACC_W-1:0];
  endfunction

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    localparam bit A_X = (t == 0) || (t == 2);
    localparam bit B_X = (t == 0) || (t == 3);
    cplx4_t pa, pb;
    logic signed [PROD_W-1:0] ar, ai, br, bi, p_re, p_im;
    logic [ACC_W-1:0] re_q, im_q, re_nxt, im_nxt;

    always_comb begin
      pa     = A_X ? a_i.x : a_i.y;
      pb     = B_X ? b_i.x : b_i.y;
      ar     = {{(PROD_W-4){pa.re[3]}}, pa.re};
      ai     = {{(PROD_W-4){pa.im[3]}}, pa.im};
      br     = {{(PROD_W-4){pb.re[3]}}, pb.re};
      bi     = {{(PROD_W-4){pb.im[3]}}, pb.im};
      // a * conj(b)
      p_re   = ar * br + ai * bi;
      p_im   = ai * br - ar * bi;
      re_nxt = sat_add(first_i ? '0 : re_q, p_re);
      im_nxt = sat_add(first_i ? '0 : im_q, p_im);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        re_q <= '0;
        im_q <= '0;
      end else if (en_i) begin
        re_q <= re_nxt;
        im_q <= im_nxt;
      end
    end

    assign sum_o[(2*N_TERMS-2*t)*ACC_W-1 -: ACC_W]   = re_nxt;
    assign sum_o[(2*N_TERMS-2*t-1)*ACC_W-1 -: ACC_W] = im_nxt;
  end
endmodule

// File: rtl/pair_correlator.sv
module pair_correlator
  import xcorr_pkg::*;
#(
  parameter int N_ANT    = 4,
  parameter int SLOT_LEN = 128,  // must exceed N_ANT/2+1
  parameter int ACC_W    = 16,
  localparam int ANT_W   = $clog2(N_ANT),
  localparam int OUT_W   = 2 * N_TERMS * ACC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [SAMP_W-1:0] sample_i,
  output logic              out_valid_o,
  output logic [ANT_W-1:0]  out_ant_a_o,
  output logic [ANT_W-1:0]  out_ant_b_o,
  output logic              out_dup_o,
  output logic [OUT_W-1:0]  out_data_o
);
  localparam int CYC_W   = $clog2(SLOT_LEN);
  localparam int N_LAGS  = N_ANT / 2 + 1;
  localparam int LAG_W   = $clog2(N_LAGS);
  localparam int HALF    = N_ANT / 2;
  localparam bit HAS_DUP = (N_ANT % 2) == 0;
  localparam logic [LAG_W-1:0] LAST_LAG = LAG_W'(N_LAGS - 1);

  logic [CYC_W-1:0] cyc;
  logic [ANT_W-1:0] slot;
  logic active, first, last, realign, primed;

  xcorr_slot_timer #(.N_ANT(N_ANT), .SLOT_LEN(SLOT_LEN)) u_timer (
    .clk_i, .rst_ni, .sync_i,
    .cyc_o(cyc), .slot_o(slot), .active_o(active), .first_o(first),
    .last_o(last), .realign_o(realign), .primed_o(primed)
  );

  dual_samp_t       tap     [N_LAGS];
  logic [OUT_W-1:0] acc_nxt [N_LAGS];

  assign tap[0] = dual_samp_t'(sample_i);

  for (genvar k = 1; k < N_LAGS; k++) begin : g_dly
    xcorr_delay_line #(.DEPTH(SLOT_LEN), .W(SAMP_W)) u_dly (
      .clk_i, .we_i(active), .ptr_i(cyc), .din_i(tap[k-1]), .dout_o(tap[k])
    );
  end

  for (genvar k = 0; k < N_LAGS; k++) begin : g_cell
    xcorr_cmac #(.ACC_W(ACC_W)) u_cmac (
      .clk_i, .rst_ni, .en_i(active), .first_i(first),
      .a_i(tap[0]), .b_i(tap[k]), .sum_o(acc_nxt[k])
    );
  end

  // serialise finished slot sums, lag ascending
  logic [OUT_W-1:0] hold_q [N_LAGS];
  logic [ANT_W-1:0] hold_slot_q;
  logic [LAG_W-1:0] emit_q;
  logic             busy_q;
  logic [ANT_W:0]   b_wide;
  logic [ANT_W-1:0] ant_b_nxt;
  logic             dup_nxt;

  always_comb begin
    b_wide = {1'b0, hold_slot_q} + (ANT_W+1)'(N_ANT) - (ANT_W+1)'(emit_q);
    if (b_wide >= (ANT_W+1)'(N_ANT)) b_wide = b_wide - (ANT_W+1)'(N_ANT);
    ant_b_nxt = b_wide[ANT_W-1:0];
    dup_nxt   = HAS_DUP && (int'(emit_q) == HALF) && (int'(hold_slot_q) >= HALF);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_LAGS; k++) hold_q[k] <= '0;
      hold_slot_q <= '0;
      emit_q      <= '0;
      busy_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_ant_a_o <= '0;
      out_ant_b_o <= '0;
      out_dup_o   <= 1'b0;
      out_data_o  <= '0;
    end else if (realign) begin
      busy_q      <= 1'b0;
      out_valid_o <= 1'b0;
      out_dup_o   <= 1'b0;
    end else begin
      if (last) begin
        for (int k = 0; k < N_LAGS; k++) hold_q[k] <= acc_nxt[k];
        hold_slot_q <= slot;
        busy_q      <= primed;
        emit_q      <= '0;
      end else if (busy_q) begin
        emit_q <= emit_q + 1'b1;
        if (emit_q == LAST_LAG) busy_q <= 1'b0;
      end
      out_valid_o <= busy_q;
      if (busy_q) begin
        out_data_o  <= hold_q[emit_q];
        out_ant_a_o <= hold_slot_q;
        out_ant_b_o <= ant_b_nxt;
        out_dup_o   <= dup_nxt;
      end else begin
        out_dup_o   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pair_correlator_chk.sv
module pair_correlator_chk #(
  parameter int N_ANT  = 4,
  localparam int ANT_W = $clog2(N_ANT),
  localparam int N_LAGS = N_ANT / 2 + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sync_i,
  input logic             out_valid_o,
  input logic [ANT_W-1:0] out_ant_a_o,
  input logic [ANT_W-1:0] out_ant_b_o,
  input logic             out_dup_o
);
  logic           seen_q;
  logic [ANT_W:0] lag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= seen_q | sync_i;
  end

  always_comb begin
    if (out_ant_a_o >= out_ant_b_o) lag = {1'b0, out_ant_a_o} - {1'b0, out_ant_b_o};
    else lag = {1'b0, out_ant_a_o} + (ANT_W+1)'(N_ANT) - {1'b0, out_ant_b_o};
  end

  a_r8_silent_before_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !out_valid_o);

  a_r2_ant_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (int'(out_ant_a_o) < N_ANT) && (int'(out_ant_b_o) < N_ANT));

  a_r5_burst_starts_lag0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> lag == '0);

  a_r5_lag_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && int'(lag) < N_LAGS - 1 && !sync_i)
      |=> out_valid_o && (lag == $past(lag) + 1'b1) && $stable(out_ant_a_o));

  a_r5_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && int'(lag) == N_LAGS - 1) |=> !out_valid_o);

  a_r7_dup_only_redundant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_dup_o |-> out_valid_o && (N_ANT % 2 == 0) && int'(lag) == N_ANT / 2
                  && int'(out_ant_a_o) >= N_ANT / 2);

  a_r7_redundant_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (N_ANT % 2 == 0) && int'(lag) == N_ANT / 2
      && int'(out_ant_a_o) >= N_ANT / 2) |-> out_dup_o);
endmodule

bind pair_correlator pair_correlator_chk #(.N_ANT(N_ANT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .out_valid_o(out_valid_o),
  .out_ant_a_o(out_ant_a_o), .out_ant_b_o(out_ant_b_o), .out_dup_o(out_dup_o)
);

// File: tb/pair_correlator_test.sv
module pair_correlator_test;
  localparam int N    = 4;
  localparam int SL   = 16;
  localparam int AW   = 10;
  localparam int FR   = N * SL;
  localparam int K    = N / 2 + 1;
  localparam int OW   = 8 * AW;
  localparam int AWD  = $clog2(N);
  localparam int MAXC = 4096;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sync_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic out_valid_o, out_dup_o;
  logic [AWD-1:0] out_ant_a_o, out_ant_b_o;
  logic [OW-1:0] out_data_o;

  always #5 clk = ~clk;

  pair_correlator #(.N_ANT(N), .SLOT_LEN(SL), .ACC_W(AW)) uut (
    .clk_i(clk), .rst_ni, .sync_i, .sample_i,
    .out_valid_o, .out_ant_a_o, .out_ant_b_o, .out_dup_o, .out_data_o
  );

  logic [15:0] hist [MAXC];
  int n = 0, base = 0, errs = 0, checks = 0;
  bit run = 0;
  string tag = "R10";

  task automatic fail(string req, string what, logic [OW-1:0] act, logic [OW-1:0] exp);
    errs++;
    $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", req, what, act, exp, n);
  endtask

  function automatic int sat(int v);
    if (v > (1 << (AW-1)) - 1) return (1 << (AW-1)) - 1;
    if (v < -(1 << (AW-1)))    return -(1 << (AW-1));
    return v;
  endfunction

  function automatic int fld(logic [15:0] v, int pos);
    logic signed [3:0] f;
    f = v[pos +: 4];
    return int'(f);
  endfunction

  // model of R1, R3, R4, R6
  function automatic logic [OW-1:0] exp_word(int c0, int lag);
    int acc [8];
    logic [OW-1:0] w;
    for (int i = 0; i < 8; i++) acc[i] = 0;
    for (int c = c0 - SL + 1; c <= c0; c++) begin
      for (int t = 0; t < 4; t++) begin
        int apos, bpos, ar, ai, br, bi;
        apos = (t == 0 || t == 2) ? 8 : 0;
        bpos = (t == 0 || t == 3) ? 8 : 0;
        ar = fld(hist[c], apos + 4);          ai = fld(hist[c], apos);
        br = fld(hist[c - lag*SL], bpos + 4); bi = fld(hist[c - lag*SL], bpos);
        acc[2*t]   = sat(acc[2*t]   + ar*br + ai*bi);
        acc[2*t+1] = sat(acc[2*t+1] + ai*br - ar*bi);
      end
    end
    w = '0;
    for (int i = 0; i < 8; i++) w[(8-i)*AW-1 -: AW] = AW'(acc[i]);
    return w;
  endfunction

  task automatic check_out();
    bit ev = 0;
    int s = 0, j = 0, c0 = 0;
    if (run) begin
      for (int jj = 0; jj < K; jj++) begin
        int c = n - 2 - jj;
        if (c >= base && (c - base) % SL == SL - 1 && (c - base) >= FR) begin
          ev = 1; j = jj; c0 = c;
        end
      end
    end
    checks++;
    if (out_valid_o !== ev) fail(tag, "valid", OW'(out_valid_o), OW'(ev));
    if (ev && out_valid_o) begin
      s = ((c0 - base) / SL) % N;
      checks++;
      if (int'(out_ant_a_o) != s) fail("R2", "ant_a", OW'(out_ant_a_o), OW'(s));
      checks++;
      if (int'(out_ant_b_o) != (s - j + N) % N) fail("R3", "ant_b", OW'(out_ant_b_o), OW'((s - j + N) % N));
      checks++;
      if (out_dup_o !== ((N % 2 == 0) && j == N/2 && s >= N/2))
        fail("R7", "dup", OW'(out_dup_o), OW'((N % 2 == 0) && j == N/2 && s >= N/2));
      checks++;
      if (out_data_o !== exp_word(c0, j)) fail("R1/R3/R4/R6", "data", out_data_o, exp_word(c0, j));
    end else if (!out_valid_o) begin
      checks++;
      if (out_dup_o !== 1'b0) fail("R7", "dup while idle", OW'(out_dup_o), '0);
    end
  endtask

  task automatic step(logic [15:0] s, bit sy);
    @(negedge clk);
    check_out();
    sample_i = s;
    sync_i   = sy;
    hist[n]  = s;
    if (sy && !(run && (n - base) % FR == 0)) base = n;  // R9 realign model
    if (sy) run = 1;
    n++;
  endtask

  function automatic logic [15:0] extreme();
    logic [15:0] v;
    for (int i = 0; i < 4; i++) v[i*4 +: 4] = $urandom_range(0, 1) ? 4'h8 : 4'h7;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    // R10 reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (out_valid_o !== 0 || out_dup_o !== 0 || out_data_o !== '0 || out_ant_a_o !== '0 || out_ant_b_o !== '0)
        fail("R10", "reset outputs", out_data_o | OW'(out_valid_o), '0);
    end
    @(negedge clk) rst_ni = 1'b1;

    tag = "R8";                       // no sync yet
    repeat (20) step(16'($urandom), 0);

    step(16'($urandom), 1);           // first alignment
    repeat (FR + SL) step(16'($urandom), 0);
    tag = "R5";
    repeat (2*FR - SL - 1) step(16'($urandom), 0);

    tag = "R9";                       // aligned syncs, no effect
    repeat (2) begin
      step(16'($urandom), 1);
      repeat (FR - 1) step(16'($urandom), 0);
    end

    tag = "R4";                       // saturation both ways
    repeat (2*FR) step((((n - base) / SL) % 2 == 0) ? 16'h8888 : 16'h7777, 0);
    repeat (2*FR) step(extreme(), 0);

    tag = "R9";                       // misaligned sync during a burst
    while ((n - base) % FR != SL + 1) step(16'($urandom), 0);
    step(16'($urandom), 1);
    repeat (FR + SL) step(16'($urandom), 0);
    tag = "R5";
    repeat (2*FR) step(16'($urandom), 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule